// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a successive-approximation converter. It drives the trial code of an external DAC and reads back one analog comparator. A single start pulse opens a sampling window whose length is set in converter clock ticks. The block then finds the result one bit per clock, from the most significant bit downward. After two more ticks it presents the result together with a one-cycle completion pulse. Each conversion picks 10-bit or 12-bit resolution when it starts.

The controller is a four-state machine.
- **IDLE**: the block waits for a request.
- **SAMPLE**: `samp_en` is high so that the external capacitor tracks the input.
- **SEARCH**: the block runs one comparator trial per clock.
- **TAIL**: the block waits out the fixed two-tick settling before it publishes the result.

The named transitions are:
- **GO** (IDLE→SAMPLE): `start` is seen while the block is idle.
- **SAMPLED** (SAMPLE→SEARCH): the sample tick counter has run out.
- **RESOLVED** (SEARCH→TAIL): the trial of bit 0 has been decided.
- **FINISH** (TAIL→IDLE): the tail counter has run out. The result register is loaded and `done` pulses.

Top module: `sar_seq`

## Requirements
- R1: After reset, `busy`, `done` and `samp_en` are 0, and `dac_code` and `result` are all zero.
- R2: The block accepts `start` only in IDLE. In the cycle after the accepting clock edge, `busy` and `samp_en` are high. `samp_en` stays high for exactly S cycles, where S is `samp_len` when it lies in 1..31.
- R3: The first trial code shown after sampling has only the top bit set: bit 11 when `res_sel`=1 (12-bit) and bit 9 when `res_sel`=0 (10-bit).
- R4: Each trial sets the current bit. When `cmp_above`=1 (the input is at or above the DAC level), the bit is kept. When `cmp_above`=0, the bit is cleared. Then the next lower bit is set for the next trial. The trial shown in search cycle i has all bits above position b=N-1-i equal to the result, bit b set, and all bits below b zero.
- R5: The search lasts N cycles. For an input of x LSB, the result is floor(x) limited to 2^N-1, so the block truncates and does not round.
- R6: `done` is high for exactly one cycle, S+N+2 clock edges after the accepting edge. `busy` falls in the same cycle that `done` rises.
- R7: `result` changes only in the cycle where `done` is high, and holds its value at all other times.
- R8: In 10-bit mode the result is right-justified on the 12-bit bus, and bits 11:10 are zero. `res_sel` is captured only at the accepting edge.
- R9: A `start` pulse during SAMPLE, SEARCH or TAIL is ignored. The completion time and the result of the running conversion do not change, and no new conversion follows it.
- R10: A `samp_len` above 31 gives 31 sample cycles, and a `samp_len` of 0 gives 1 sample cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, sampled while idle |
| samp_len | input | 8 | Requested sample ticks (clamped to 1..31) |
| res_sel | input | 1 | 1 = 12-bit, 0 = 10-bit conversion |
| cmp_above | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| dac_code | output | 12 | Trial code sent to the DAC |
| samp_en | output | 1 | Sample switch enable |
| busy | output | 1 | High from the accepting edge until completion |
| result | output | 12 | Last completed conversion result |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench counts clock edges from the edge that accepts `start`. It expects `samp_en` to be high in cycles 0 to S-1 and the search trials in cycles S to S+N-1. It expects `done`, the falling `busy` and the new `result` at edge S+N+2, and a low `done` one cycle later. Outputs are sampled on the falling clock edge after each rising edge, and every comparison is made against the cycle index computed for that conversion. The bench works out the expected trial codes from the truncated result and a bit position, so it does not step its own copy of the search. Stray `start` pulses are placed at chosen cycle indices so that they fall into each busy state.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_SEARCH,
        ST_TAIL
    } sar_state_t;
endpackage

// File: rtl/sar_tick_cnt.sv
// Down counter that reports when it has reached zero; reloads on request.
module sar_tick_cnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sar_bit_search.sv
// Trial-code register and bit pointer of the binary search.
module sar_bit_search #(
    parameter int CODE_W   = 12,
    parameter int NARROW_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              init,
    input  logic              wide,
    input  logic              step,
    input  logic              keep,
    output logic [CODE_W-1:0] code,
    output logic              last
);
    localparam int POS_W = $clog2(CODE_W);

    logic [POS_W-1:0]  pos_q;
    logic [POS_W-1:0]  pos_dn;
    logic [POS_W-1:0]  pos_top;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] code_nx;

    assign pos_top = wide ? POS_W'(CODE_W - 1) : POS_W'(NARROW_W - 1);
    assign pos_dn  = pos_q - 1'b1;

    // Decide the current bit, then raise the next lower one as the new guess.
    always_comb begin
        code_nx = code_q;
        if (!keep)
            code_nx[pos_q] = 1'b0;
        if (pos_q != '0)
            code_nx[pos_dn] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            pos_q  <= '0;
        end else if (clear) begin
            code_q <= '0;
            pos_q  <= '0;
        end else if (init) begin
            code_q <= CODE_W'(1) << pos_top;
            pos_q  <= pos_top;
        end else if (step) begin
            code_q <= code_nx;
            if (pos_q != '0)
                pos_q <= pos_dn;
        end
    end

    assign code = code_q;
    assign last = (pos_q == '0);
endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_seq_pkg::*;
#(
    parameter int CODE_W     = 12,
    parameter int NARROW_W   = 10,
    parameter int LEN_W      = 8,
    parameter int SAMP_MAX   = 31,
    parameter int TAIL_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  samp_len,
    input  logic              res_sel,
    input  logic              cmp_above,
    output logic [CODE_W-1:0] dac_code,
    output logic              samp_en,
    output logic              busy,
    output logic [CODE_W-1:0] result,
    output logic              done
);
    localparam int CNT_MAX = (SAMP_MAX > TAIL_TICKS) ? SAMP_MAX : TAIL_TICKS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    sar_state_t        state_q, state_d;
    logic [CNT_W-1:0]  samp_m1;
    logic [CNT_W-1:0]  tick_val;
    logic              tick_exp;
    logic              tick_load;
    logic              wide_q;
    logic              search_step;
    logic              search_last;
    logic [CODE_W-1:0] code;
    logic              go, sampled, resolved, finish;

    // Clamp the requested sample length to 1..SAMP_MAX, minus one for the counter.
    always_comb begin
        if (samp_len == '0)
            samp_m1 = '0;
        else if (samp_len > LEN_W'(SAMP_MAX))
            samp_m1 = CNT_W'(SAMP_MAX - 1);
        else
            samp_m1 = CNT_W'(samp_len - 1'b1);
    end

    assign go       = (state_q == ST_IDLE)   && start;
    assign sampled  = (state_q == ST_SAMPLE) && tick_exp;
    assign resolved = (state_q == ST_SEARCH) && search_last;
    assign finish   = (state_q == ST_TAIL)   && tick_exp;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go)       state_d = ST_SAMPLE;
            ST_SAMPLE: if (sampled)  state_d = ST_SEARCH;
            ST_SEARCH: if (resolved) state_d = ST_TAIL;
            ST_TAIL:   if (finish)   state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        samp_en     = 1'b0;
        busy        = 1'b1;
        search_step = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy        = 1'b0;
            ST_SAMPLE: samp_en     = 1'b1;
            ST_SEARCH: search_step = 1'b1;
            ST_TAIL:   busy        = 1'b1;
            default:   busy        = 1'b0;
        endcase
    end

    assign tick_load = go || resolved;
    assign tick_val  = go ? samp_m1 : CNT_W'(TAIL_TICKS - 1);

    sar_tick_cnt #(.W(CNT_W)) u_ticks (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tick_load),
        .load_val (tick_val),
        .expired  (tick_exp)
    );

    sar_bit_search #(.CODE_W(CODE_W), .NARROW_W(NARROW_W)) u_search (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (go),
        .init  (sampled),
        .wide  (wide_q),
        .step  (search_step),
        .keep  (cmp_above),
        .code  (code),
        .last  (search_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wide_q <= 1'b0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            if (go)
                wide_q <= res_sel;
            if (finish)
                result <= code;
            done <= finish;
        end
    end

    assign dac_code = code;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int CODE_W   = 12,
    parameter int SAMP_MAX = 31
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              samp_en,
    input logic              done,
    input logic [CODE_W-1:0] dac_code,
    input logic [CODE_W-1:0] result
);
    logic [7:0] samp_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            samp_run <= '0;
        else if (!samp_en)
            samp_run <= '0;
        else if (samp_run != 8'hFF)
            samp_run <= samp_run + 1'b1;
    end

    // R2
    samp_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        samp_en |-> busy);

    // R3
    first_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $fell(samp_en)) |-> ($countones(dac_code) == 1));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

    // R10
    samp_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        samp_run <= 8'(SAMP_MAX));
endmodule

bind sar_seq sar_seq_chk #(.CODE_W(CODE_W), .SAMP_MAX(SAMP_MAX)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .samp_en  (samp_en),
    .done     (done),
    .dac_code (dac_code),
    .result   (result)
);

// File: tb/test_sar_seq.sv
module test_sar_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  samp_len = 8'd0;
    logic        res_sel = 1'b0;
    logic        cmp_above;
    logic [11:0] dac_code;
    logic        samp_en;
    logic        busy;
    logic [11:0] result;
    logic        done;

    int vin16 = 0;      // analog input in 1/16 LSB units
    int total = 0;
    int bad = 0;
    int last_res = 0;

    always #4 clk = ~clk;

    // Ideal comparator: the input is at or above the DAC level.
    always_comb cmp_above = (vin16 >= int'(dac_code) * 16);

    sar_seq i_sar_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .samp_len  (samp_len),
        .res_sel   (res_sel),
        .cmp_above (cmp_above),
        .dac_code  (dac_code),
        .samp_en   (samp_en),
        .busy      (busy),
        .result    (result),
        .done      (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic convert(input int v16, input int len, input bit wide, input int stray_j);
        int n, s, full, expv, samp_cnt, b, trial;
        bit seq_ok, hold_ok, early_done;
        n    = wide ? 12 : 10;
        s    = (len == 0) ? 1 : ((len > 31) ? 31 : len);
        full = (1 << n) - 1;
        expv = v16 / 16;
        if (expv > full) expv = full;
        samp_cnt = 0; seq_ok = 1; hold_ok = 1; early_done = 0;
        @(negedge clk);
        vin16 = v16; samp_len = 8'(len); res_sel = wide; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(busy && samp_en, "R2 busy/samp_en after start", int'({busy, samp_en}), 3);
        for (int j = 0; j <= s + n + 2; j++) begin
            start = (j == stray_j);
            if (samp_en) samp_cnt++;
            if (j == s)
                chk(dac_code == 12'(1 << (n - 1)), "R3 first trial", int'(dac_code), 1 << (n - 1));
            if (j >= s && j < s + n) begin
                b = n - 1 - (j - s);
                trial = ((expv >> (b + 1)) << (b + 1)) | (1 << b);
                if (int'(dac_code) != trial) seq_ok = 0;
            end
            if (j < s + n + 2) begin
                if (int'(result) != last_res) hold_ok = 0;
                if (done) early_done = 1;
                @(posedge clk);
                @(negedge clk);
            end
        end
        start = 1'b0;
        chk(seq_ok, "R4 trial sequence", int'(dac_code), expv);
        chk(hold_ok, "R7 result held during conversion", int'(result), last_res);
        chk(!early_done && done, "R6 done at S+N+2", int'(done), 1);
        chk(!busy, "R6 busy falls with done", int'(busy), 0);
        chk(int'(result) == expv, "R5 truncated result", int'(result), expv);
        if (!wide)
            chk(result[11:10] == 2'b00, "R8 right-justified", int'(result[11:10]), 0);
        if (len == 0 || len > 31)
            chk(samp_cnt == s, "R10 clamped sample length", samp_cnt, s);
        else
            chk(samp_cnt == s, "R2 sample length", samp_cnt, s);
        @(posedge clk);
        @(negedge clk);
        chk(!done, "R6 done one cycle", int'(done), 0);
        if (stray_j >= 0)
            chk(!busy && int'(result) == expv, "R9 stray start ignored", int'(busy), 0);
        last_res = expv;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !samp_en, "R1 reset flags", int'({busy, done, samp_en}), 0);
        chk(dac_code == 12'd0 && result == 12'd0, "R1 reset codes", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R5 fractional input 12.5625 LSB, 31 sample ticks, 12-bit: 45-tick latency
        convert(201, 31, 1'b1, -1);
        convert(4095 * 16 + 15, 5, 1'b1, -1);
        convert(0, 1, 1'b1, -1);
        // R10 clamping
        convert(2048 * 16, 0, 1'b1, -1);
        convert(2047 * 16 + 8, 40, 1'b1, -1);
        convert(1000 * 16 + 3, 255, 1'b0, -1);
        // R8 over-range input in 10-bit mode saturates
        convert(4000 * 16, 3, 1'b0, -1);
        // R9 stray starts in SAMPLE, SEARCH and TAIL
        convert(777 * 16, 6, 1'b1, 2);
        convert(333 * 16 + 9, 6, 1'b0, 10);
        convert(3210 * 16 + 1, 4, 1'b1, 4 + 12 + 1);
        // R5 R4 exhaustive 10-bit sweep
        for (int c = 0; c < 1024; c++)
            convert(c * 16 + (c % 16), 1 + (c % 3), 1'b0, -1);
        // R5 R4 strided 12-bit sweep
        for (int c = 0; c < 4096; c += 7)
            convert(c * 16 + ((c * 5) % 16), 1 + (c % 4), 1'b1, -1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule